// File: doc/BRIEF.md
# Configurable Digital Input Conditioner

This block cleans up one raw, asynchronous digital input before counters and event logic use it. The pin is brought into the clock domain through a two-stage synchronizer, optionally inverted, and then passed through a stable-run noise filter. The filter accepts a new level only after the input has shown that level for a chosen number of consecutive clock samples. The number of samples comes from a configuration code. In general-purpose mode the code names a filter time. In pulse mode the code names the highest pulse rate that must still pass.

Until the filter first qualifies an input level, the output shows a programmable initial level. After that, the output follows the filtered input. Each change of the filtered level produces a one-cycle rise or fall strobe. A maskable event output combines the rise, fall, Low-level and High-level conditions.

All sample counts are derived from the parameter `CLK_KHZ`, the system clock frequency in kHz. The default is 80 MHz.

Top module: `din_conditioner`

## Requirements
- R1: While reset is asserted and on the first clock after it is released, `level_o` equals `cfg_init_high`, and `rise_o` and `fall_o` are 0.
- R2: When `cfg_invert` is 1, the filtered level is the complement of the pin. When it is 0, the filtered level equals the pin.
- R3: With `cfg_pulse_mode`=0, `cfg_sel` selects a filter time. The codes 0 to 8 stand for 0, 10 µs, 50 µs, 100 µs, 200 µs, 400 µs, 600 µs, 1 ms and 5 ms, and the codes 9 to 15 behave like code 8. The sample count is N = CLK_KHZ·t/1000, rounded down. After the pin takes a new level just after clock edge 0, `level_o` changes at edge N+2, or at edge 3 when N is 0 or 1.
- R4: A pin level that lasts N−1 cycles or fewer leaves `level_o` unchanged. A level that lasts exactly N cycles is accepted.
- R5: Filter code 0 in general-purpose mode bypasses filtering. `level_o` follows the pin with three clock edges of latency.
- R6: With `cfg_pulse_mode`=1, `cfg_sel[2:0]` selects a maximum rate. The codes 0 to 7 stand for 10, 100, 200, 500, 1000, 2000, 4000 and 8000 kpps. The sample count is N = max(1, CLK_KHZ/(2·rate_kpps)), rounded down, with the latency rule of R3.
- R7: After reset, `level_o` holds `cfg_init_high` until the first input level is qualified. Samples are counted from the third clock edge after reset release, so with a steady pin the qualified level appears at edge max(N,1)+2.
- R8: `rise_o` or `fall_o` is high for exactly the one cycle in which `level_o` goes from 0 to 1 or from 1 to 0. This includes the first qualified level when it differs from the initial level. The two strobes are never high together.
- R9: `event_o` is the OR of the enabled conditions. The bits of `cfg_evt_mask` enable them as follows: bit 0 for a rise strobe, bit 1 for a fall strobe, bit 2 for `level_o`=0, and bit 3 for `level_o`=1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| pin_i | input | 1 | Raw asynchronous input pin |
| cfg_invert | input | 1 | 1 = invert the pin polarity |
| cfg_pulse_mode | input | 1 | 0 = general-purpose filter times, 1 = pulse-rate filter |
| cfg_sel | input | 4 | Filter time or pulse-rate code |
| cfg_init_high | input | 1 | Level shown before the first qualified input |
| cfg_evt_mask | input | 4 | Event enables: [0] rise, [1] fall, [2] low, [3] high |
| level_o | output | 1 | Filtered, synchronized level |
| rise_o | output | 1 | One-cycle strobe on a 0 to 1 change of `level_o` |
| fall_o | output | 1 | One-cycle strobe on a 1 to 0 change of `level_o` |
| event_o | output | 1 | Masked combination of edge and level conditions |

## Verification
The bench builds the block with `CLK_KHZ` = 400. At that clock, every general-purpose code maps to between 0 and 2000 samples, so the whole time table and the clamped codes can be measured edge by edge within a short run. The same value makes the pulse table reach both an N of 20 and the floor of 1, so the rounding and the minimum-of-one rule are both exercised. It also makes the N and N−1 glitch boundary only tens of cycles wide.

// File: rtl/dincond_pkg.sv
// Package: shared filter-table arithmetic for the input conditioner.
// Assumes the clock is given in kHz and that the filter times are whole microseconds.
package dincond_pkg;

    // General-purpose filter time in microseconds for a code; codes above 8 clamp to 5 ms.
    function automatic int dc_gen_us(input int code);
        case (code)
            0:       return 0;
            1:       return 10;
            2:       return 50;
            3:       return 100;
            4:       return 200;
            5:       return 400;
            6:       return 600;
            7:       return 1000;
            default: return 5000;
        endcase
    endfunction

    // Maximum pulse rate in kpps for a pulse-mode code.
    function automatic int dc_rate_kpps(input int code);
        case (code)
            0:       return 10;
            1:       return 100;
            2:       return 200;
            3:       return 500;
            4:       return 1000;
            5:       return 2000;
            6:       return 4000;
            default: return 8000;
        endcase
    endfunction

    // Sample count for a general-purpose code.
    function automatic int dc_gen_ticks(input int khz, input int code);
        return (khz * dc_gen_us(code)) / 1000;
    endfunction

    // Sample count for a pulse code: half the shortest period, never below one.
    function automatic int dc_pulse_ticks(input int khz, input int code);
        int t;
        t = khz / (2 * dc_rate_kpps(code));
        return (t < 1) ? 1 : t;
    endfunction

    // Largest count any code can ask for; this sizes the run counter.
    function automatic int dc_max_ticks(input int khz);
        int a;
        int b;
        a = dc_gen_ticks(khz, 8);
        b = dc_pulse_ticks(khz, 0);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/dincond_sync.sv
// Module: two-flop synchronizer followed by a polarity select.
// Assumes pin_i is fully asynchronous. The inversion sits after the flops, so a
// polarity change reaches the filter on the next cycle and is qualified like any edge.
module dincond_sync (
    input  logic clk,
    input  logic rst_n,
    input  logic pin_i,
    input  logic invert_i,
    output logic s_o
);
    logic meta_q;
    logic sync_q;

    // Purpose: bring the raw pin into the clock domain over two stages.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            meta_q <= 1'b0;
            sync_q <= 1'b0;
        end else begin
            meta_q <= pin_i;
            sync_q <= meta_q;
        end
    end

    // Purpose: apply the configured polarity to the synchronized sample.
    always_comb s_o = sync_q ^ invert_i;

endmodule

// File: rtl/dincond_period_sel.sv
// Module: maps the mode and code to a filter sample count.
// Assumes CW is wide enough for dc_max_ticks(CLK_KHZ). Both tables are built as
// constants by generate loops from the package arithmetic.
module dincond_period_sel
    import dincond_pkg::*;
#(
    parameter int CLK_KHZ = 80000,
    parameter int CW      = 20
) (
    input  logic          pulse_i,
    input  logic [3:0]    sel_i,
    output logic [CW-1:0] n_o
);
    localparam int GEN_CODES   = 9;
    localparam int PULSE_CODES = 8;

    logic [CW-1:0] gen_tab [GEN_CODES];
    logic [CW-1:0] pls_tab [PULSE_CODES];

    for (genvar g = 0; g < GEN_CODES; g++) begin : g_gen_tab
        assign gen_tab[g] = CW'(dc_gen_ticks(CLK_KHZ, g));
    end

    for (genvar p = 0; p < PULSE_CODES; p++) begin : g_pls_tab
        assign pls_tab[p] = CW'(dc_pulse_ticks(CLK_KHZ, p));
    end

    // Purpose: select the count for the mode; general codes past 8 clamp to the longest time.
    always_comb begin
        if (pulse_i)
            n_o = pls_tab[sel_i[2:0]];
        else if (sel_i > 4'd8)
            n_o = gen_tab[GEN_CODES-1];
        else
            n_o = gen_tab[sel_i];
    end

endmodule

// File: rtl/dincond_filter.sv
// Module: stable-run noise filter with an initial-level hold.
// Accepts the sample level once it has been seen on n_ticks_i consecutive edges
// (a count of 0 behaves like 1). Counting starts two edges after reset, once the
// synchronizer holds real pin data. Until the first acceptance the output tracks
// init_i.
module dincond_filter #(
    parameter int MAXT = 400000,
    parameter int CW   = 20
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          s_i,
    input  logic          init_i,
    input  logic [CW-1:0] n_ticks_i,
    output logic          level_o,
    output logic          armed_o
);
    logic [1:0]    fill_q;
    logic          cand_q;
    logic [CW-1:0] cnt_q;
    logic          armed_q;
    logic          f_q;
    logic          primed;
    logic [CW-1:0] run_next;
    logic          accept;

    // Purpose: length of the current run of equal samples, saturated at MAXT.
    always_comb begin
        primed = (fill_q == 2'd2);
        if (!primed)
            run_next = '0;
        else if (s_i != cand_q)
            run_next = CW'(1);
        else if (cnt_q >= CW'(MAXT))
            run_next = CW'(MAXT);
        else
            run_next = cnt_q + CW'(1);
        accept = primed && (run_next >= n_ticks_i);
    end

    // Purpose: mark the synchronizer as holding real pin data after two edges.
    always_ff @(posedge clk) begin
        if (!rst_n)
            fill_q <= 2'd0;
        else if (!primed)
            fill_q <= fill_q + 2'd1;
    end

    // Purpose: track the candidate level and how long it has run.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= 1'b0;
            cnt_q  <= '0;
        end else begin
            cand_q <= s_i;
            cnt_q  <= run_next;
        end
    end

    // Purpose: update the output level, holding the initial level until the first acceptance.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            f_q     <= init_i;
            armed_q <= 1'b0;
        end else begin
            if (accept)
                f_q <= s_i;
            else if (!armed_q)
                f_q <= init_i;
            armed_q <= armed_q | accept;
        end
    end

    assign level_o = f_q;
    assign armed_o = armed_q;

    // R3: the run counter never leaves its saturation range.
    assert_cnt_bounded_R3: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= CW'(MAXT));

    // R4: an armed output changes only after a long enough run.
    assert_change_needs_run_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_q && $past(armed_q) && (f_q != $past(f_q))) |-> (cnt_q >= $past(n_ticks_i)));

    // R7: qualification is sticky.
    assert_armed_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $past(armed_q) |-> armed_q);

    // R7: before the first acceptance the output is the configured initial level.
    assert_hold_init_R7: assert property (@(posedge clk) disable iff (!rst_n)
        !armed_q |-> (f_q == $past(init_i)));

endmodule

// File: rtl/dincond_edge_event.sv
// Module: rise/fall strobes and the masked event output.
// Assumes level_i is registered. Strobes fire in the cycle the level differs from
// its previous value, once the filter is armed.
module dincond_edge_event (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       level_i,
    input  logic       armed_i,
    input  logic       init_i,
    input  logic [3:0] mask_i,
    output logic       rise_o,
    output logic       fall_o,
    output logic       event_o
);
    logic prev_q;

    // Purpose: remember last cycle's level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n)
            prev_q <= init_i;
        else
            prev_q <= level_i;
    end

    // Purpose: form the strobes and combine the enabled conditions.
    always_comb begin
        rise_o  = armed_i &&  level_i && !prev_q;
        fall_o  = armed_i && !level_i &&  prev_q;
        event_o = (mask_i[0] && rise_o) || (mask_i[1] && fall_o) ||
                  (mask_i[2] && !level_i) || (mask_i[3] && level_i);
    end

    // R8: the two strobes are never high together.
    assert_one_strobe_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !(rise_o && fall_o));

    // R8: a rise strobe comes with a high level that was low one cycle before.
    assert_rise_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        rise_o |-> (level_i && !$past(level_i)));

    // R8: a fall strobe comes with a low level that was high one cycle before.
    assert_fall_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
        fall_o |-> (!level_i && $past(level_i)));

    // R9: with every enable clear, no event is reported.
    assert_event_masked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_i == 4'd0) |-> !event_o);

endmodule

// File: rtl/din_conditioner.sv
// Module: top of the digital input conditioner.
// Chain: synchronizer and polarity, filter-count select, stable-run filter, then edge/event.
// Assumes cfg inputs are quasi-static, held steady by the surrounding logic.
module din_conditioner
    import dincond_pkg::*;
#(
    parameter int CLK_KHZ = 80000
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       pin_i,
    input  logic       cfg_invert,
    input  logic       cfg_pulse_mode,
    input  logic [3:0] cfg_sel,
    input  logic       cfg_init_high,
    input  logic [3:0] cfg_evt_mask,
    output logic       level_o,
    output logic       rise_o,
    output logic       fall_o,
    output logic       event_o
);
    localparam int MAXT = dc_max_ticks(CLK_KHZ);
    localparam int CW   = $clog2(MAXT + 2);

    logic          s_w;
    logic [CW-1:0] n_w;
    logic          lvl_w;
    logic          armed_w;

    dincond_sync u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .pin_i    (pin_i),
        .invert_i (cfg_invert),
        .s_o      (s_w)
    );

    dincond_period_sel #(.CLK_KHZ(CLK_KHZ), .CW(CW)) u_psel (
        .pulse_i (cfg_pulse_mode),
        .sel_i   (cfg_sel),
        .n_o     (n_w)
    );

    dincond_filter #(.MAXT(MAXT), .CW(CW)) u_filt (
        .clk       (clk),
        .rst_n     (rst_n),
        .s_i       (s_w),
        .init_i    (cfg_init_high),
        .n_ticks_i (n_w),
        .level_o   (lvl_w),
        .armed_o   (armed_w)
    );

    dincond_edge_event u_evt (
        .clk     (clk),
        .rst_n   (rst_n),
        .level_i (lvl_w),
        .armed_i (armed_w),
        .init_i  (cfg_init_high),
        .mask_i  (cfg_evt_mask),
        .rise_o  (rise_o),
        .fall_o  (fall_o),
        .event_o (event_o)
    );

    assign level_o = lvl_w;

endmodule

// File: tb/sim_din_conditioner.sv
// Bench: table-driven latency sweep followed by directed reset, glitch and event tests.
module sim_din_conditioner;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pin_i = 1'b0;
    logic       cfg_invert = 1'b0;
    logic       cfg_pulse_mode = 1'b0;
    logic [3:0] cfg_sel = 4'd0;
    logic       cfg_init_high = 1'b0;
    logic [3:0] cfg_evt_mask = 4'd0;
    logic       level_o, rise_o, fall_o, event_o;

    int tests = 0;
    int fails = 0;
    int cyc = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    din_conditioner #(.CLK_KHZ(400)) u0 (
        .clk(clk), .rst_n(rst_n), .pin_i(pin_i), .cfg_invert(cfg_invert),
        .cfg_pulse_mode(cfg_pulse_mode), .cfg_sel(cfg_sel), .cfg_init_high(cfg_init_high),
        .cfg_evt_mask(cfg_evt_mask), .level_o(level_o), .rise_o(rise_o),
        .fall_o(fall_o), .event_o(event_o)
    );

    // Vector: [21] pulse mode, [20:17] code, [16] invert, [15:0] expected N at 400 kHz
    localparam int NV = 15;
    localparam logic [21:0] VECS [NV] = '{
        {1'b0, 4'd0,  1'b0, 16'd0},     // R5 bypass
        {1'b0, 4'd1,  1'b0, 16'd4},     // R3 10 us
        {1'b0, 4'd2,  1'b0, 16'd20},    // R3 50 us
        {1'b0, 4'd3,  1'b0, 16'd40},    // R3 100 us
        {1'b0, 4'd4,  1'b0, 16'd80},    // R3 200 us
        {1'b0, 4'd5,  1'b0, 16'd160},   // R3 400 us
        {1'b0, 4'd6,  1'b0, 16'd240},   // R3 600 us
        {1'b0, 4'd7,  1'b0, 16'd400},   // R3 1 ms
        {1'b0, 4'd8,  1'b0, 16'd2000},  // R3 5 ms
        {1'b0, 4'd12, 1'b0, 16'd2000},  // R3 clamp
        {1'b1, 4'd0,  1'b0, 16'd20},    // R6 10 kpps
        {1'b1, 4'd1,  1'b0, 16'd2},     // R6 100 kpps
        {1'b1, 4'd2,  1'b0, 16'd1},     // R6 200 kpps
        {1'b1, 4'd7,  1'b0, 16'd1},     // R6 8000 kpps floor
        {1'b0, 4'd2,  1'b1, 16'd20}     // R2 inverted
    };

    task automatic check(input string req, input int act, input int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic summary();
        if (!done) begin
            done = 1'b1;
            $display("[TB] %0d tests run, %0d failed", tests, fails);
            $finish;
        end
    endtask

    // Watchdog: an overrun counts as a failure and still reports.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !done) begin
            fails++;
            $display("FAIL watchdog: actual %0d expected below 150000", cyc);
            summary();
        end
    end

    // Toggle the pin at a negedge and count edges until level_o changes.
    task automatic measure(input string req, input int n, input logic inv);
        int k = 0;
        logic old = level_o;
        int exp_k = ((n < 1) ? 1 : n) + 2;
        pin_i = ~pin_i;
        while (k < n + 10) begin
            @(posedge clk); k++;
            @(negedge clk);
            if (level_o != old) break;
        end
        check({req, " latency"}, k, exp_k);
        check({req, " level"}, int'(level_o), int'(pin_i ^ inv));
        check("R8 rise strobe", int'(rise_o), int'(!old));
        check("R8 fall strobe", int'(fall_o), int'(old));
        check("R9 rise event", int'(event_o), int'(!old));
        @(negedge clk);
        check("R8 single cycle", int'(rise_o | fall_o), 0);
    endtask

    initial begin
        int seen;
        // R1 / R7: reset with initial level High and pin Low, N = 40
        cfg_sel = 4'd3; cfg_init_high = 1'b1; pin_i = 1'b0;
        repeat (4) @(negedge clk);
        check("R1 level in reset", int'(level_o), 1);
        check("R1 strobes in reset", int'(rise_o | fall_o), 0);
        rst_n = 1'b1;
        begin
            int k = 0;
            while (k < 60) begin
                @(posedge clk); k++;
                @(negedge clk);
                if (k == 1) check("R1 level after release", int'(level_o), 1);
                if (level_o != 1'b1) break;
            end
            check("R7 first qualified edge", k, 42);
            check("R7 qualified level", int'(level_o), 0);
            check("R8 fall on first qualify", int'(fall_o), 1);
        end

        // R1: initial Low held in reset
        @(negedge clk); rst_n = 1'b0; cfg_init_high = 1'b0; pin_i = 1'b1;
        repeat (3) @(negedge clk);
        check("R1 init low in reset", int'(level_o), 0);
        rst_n = 1'b1; pin_i = 1'b0;
        repeat (60) @(negedge clk);

        // Table sweep: R2, R3, R5, R6
        cfg_evt_mask = 4'b0001;
        for (int v = 0; v < NV; v++) begin
            logic [21:0] vec = VECS[v];
            int n = int'(vec[15:0]);
            cfg_pulse_mode = vec[21];
            cfg_sel = vec[20:17];
            cfg_invert = vec[16];
            repeat (n + 8) @(negedge clk);
            check("R2 rest level", int'(level_o), int'(pin_i ^ vec[16]));
            measure(vec[21] ? "R6" : (vec[16] ? "R2" : (n == 0 ? "R5" : "R3")), n, vec[16]);
            repeat (n + 8) @(negedge clk);
            measure("R3 return", n, vec[16]);
        end

        // R4: glitch boundary, N = 20
        cfg_invert = 1'b0; cfg_pulse_mode = 1'b0; cfg_sel = 4'd2; pin_i = 1'b0;
        repeat (40) @(negedge clk);
        seen = 0;
        pin_i = 1'b1;
        repeat (19) @(negedge clk);
        pin_i = 1'b0;
        for (int i = 0; i < 40; i++) begin
            @(negedge clk);
            if (level_o) seen++;
        end
        check("R4 N-1 glitch ignored", seen, 0);
        pin_i = 1'b1;
        repeat (20) @(negedge clk);
        pin_i = 1'b0;
        seen = 0;
        for (int i = 0; i < 10; i++) begin
            @(negedge clk);
            if (level_o) seen++;
        end
        check("R4 N-cycle level accepted", int'(seen > 0), 1);
        repeat (40) @(negedge clk);

        // R9: level-condition enables
        check("R9 low level", int'(level_o), 0);
        cfg_evt_mask = 4'b0100; #1;
        check("R9 low enabled", int'(event_o), 1);
        cfg_evt_mask = 4'b1000; #1;
        check("R9 high enabled while low", int'(event_o), 0);
        cfg_evt_mask = 4'b0000; #1;
        check("R9 none enabled", int'(event_o), 0);
        pin_i = 1'b1;
        repeat (40) @(negedge clk);
        cfg_evt_mask = 4'b1000; #1;
        check("R9 high enabled", int'(event_o), 1);
        cfg_evt_mask = 4'b0110; #1;
        check("R9 low/fall while high", int'(event_o), 0);

        summary();
    end

endmodule